// File: doc/BRIEF.md
# Flash Bus Front End

This block sits between the external parallel bus of a NOR-style flash device and its internal command logic. It turns the power-down, two select, read-strobe and write-strobe inputs into one bus mode. Depending on that mode it drives the data bus or leaves it undriven. It answers identifier reads with fixed manufacturer and device codes. It captures write data and passes it on as a single clocked pulse. It also produces an open-drain ready/busy line from the status of the write state machine.

A single input selects the data width. In word mode all sixteen data lines are used. In byte mode only the low eight lines carry data. All strobes are sampled on the system clock. The write pulse is accepted or rejected according to the programming-voltage flag that is sampled on the same edge.

Top module: `flash_bus_front`

## Requirements
- R1: `bus_mode` reports the decoded mode with the codes power-down=0, standby=1, output-disable=2, read=3, identifier=4 and write=5. While `pd_n` is low the mode is 0, `dq_oe` is 00 and `rb_pull_low` is 0, whatever the other strobes do. A write that is cut short by power-down produces no pulse.
- R2: With `pd_n` high and either `sel_a_n` or `sel_b_n` high, the mode is standby (1) and `dq_oe` is 00.
- R3: With both selects low and both `rd_en_n` and `wr_en_n` high, the mode is output-disable (2) and `dq_oe` is 00.
- R4: With both selects low, `rd_en_n` low, `wr_en_n` high and `id_sel` low, the block is in read mode. In word mode `dq_out` equals `array_rdata` and `dq_oe` is 11. In byte mode `dq_out` is {8'h00, `array_rdata[7:0]`} and `dq_oe` is 01.
- R5: In the read condition with `id_sel` high and `word_mode` high, the mode is identifier (4) and `dq_oe` is 11. With `addr[1]`=0 the output is 16'h00B0 and with `addr[1]`=1 it is 16'h66A8, provided every other address bit (including bit 0) is zero. Otherwise the output is 16'h0000.
- R6: In identifier mode with `word_mode` low, `dq_oe` is 01. `addr[0]` selects between the low code bytes 8'hB0 and 8'hA8, shown as {8'h00, code}. The result is 16'h0000 if any higher address bit is set.
- R7: Write mode (5) means both selects low, `wr_en_n` low and `pd_n` high, and `dq_oe` is 00 in it. The write ends at the first clock where the write condition no longer holds, whether `wr_en_n` or a select went high. In the following cycle exactly one one-cycle pulse appears. `wr_data` then holds the `dq_in` value from the last write cycle, with the upper byte forced to zero if `word_mode` was low in that cycle.
- R8: At the clock where a write ends, if `vprog_ok` is high the pulse appears on `wr_accept`, otherwise on `wr_reject`. The two never assert together.
- R9: `rb_pull_low` is 1 exactly when `wsm_busy` is 1, `erase_susp` is 0 and `pd_n` is 1.
- R10: While the write state machine is busy, `rb_pull_low` does not depend on `rd_en_n` or on the bus mode. A status read during a busy operation still shows busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Low selects deep power-down |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| id_sel | input | 1 | From command logic: reads return identifier codes |
| addr | input | ADDR_W | Bus address |
| dq_in | input | 16 | Data arriving from the bus |
| array_rdata | input | 16 | Data from the memory array |
| vprog_ok | input | 1 | Programming voltage valid |
| wsm_busy | input | 1 | Write state machine busy |
| erase_susp | input | 1 | Erase is suspended |
| bus_mode | output | 3 | Decoded bus mode code |
| dq_out | output | 16 | Data to drive onto the bus |
| dq_oe | output | 2 | Drive enables, bit 0 low byte, bit 1 high byte |
| wr_accept | output | 1 | One-cycle pulse: write accepted |
| wr_reject | output | 1 | One-cycle pulse: write refused, no programming voltage |
| wr_data | output | 16 | Data of the most recent write |
| rb_pull_low | output | 1 | Open-drain enable: 1 pulls ready/busy low |

## Verification
The assertions assume that the strobes, `vprog_ok` and `pd_n` are already synchronous to `clk` and stay stable around each rising edge. The bench meets this by changing every input one time unit after a rising edge. The checks assume that `wsm_busy` and `erase_susp` come from a well-behaved source. A small stub in the bench raises busy for a few cycles after each accepted write, and also drives both inputs in patterns it chooses freely. Random phases keep the address mostly in the low range so that identifier reads are reached, and now and then set high address bits to exercise the zero-result case.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = DQ_W / 2;

    localparam logic [DQ_W-1:0] MFR_CODE = 16'h00B0;
    localparam logic [DQ_W-1:0] DEV_CODE = 16'h66A8;

    typedef enum logic [2:0] {
        BM_PD    = 3'd0,
        BM_STBY  = 3'd1,
        BM_ODIS  = 3'd2,
        BM_READ  = 3'd3,
        BM_ID    = 3'd4,
        BM_WRITE = 3'd5
    } bus_mode_e;

    typedef struct packed {
        logic pd_n;
        logic sel_a_n;
        logic sel_b_n;
        logic rd_en_n;
        logic wr_en_n;
        logic id_sel;
    } strobes_t;

    function automatic bus_mode_e decode_mode(input strobes_t s);
        if (!s.pd_n)                    return BM_PD;
        else if (s.sel_a_n || s.sel_b_n) return BM_STBY;
        else if (!s.wr_en_n)            return BM_WRITE;
        else if (s.rd_en_n)             return BM_ODIS;
        else if (s.id_sel)              return BM_ID;
        else                            return BM_READ;
    endfunction

    function automatic logic [DQ_W-1:0] narrow(input logic word_mode,
                                               input logic [DQ_W-1:0] d);
        return word_mode ? d : {{(DQ_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/fbf_mode_dec.sv
module fbf_mode_dec
    import flash_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  strobes_t  strobes,
    output bus_mode_e mode
);
    assign mode = decode_mode(strobes);

    AST_PD_WINS: assert property (@(posedge clk) disable iff (rst)
        !strobes.pd_n |-> mode == BM_PD);  // R1
    AST_STBY_SEL: assert property (@(posedge clk) disable iff (rst)
        (strobes.pd_n && (strobes.sel_a_n || strobes.sel_b_n)) |-> mode == BM_STBY);  // R2
endmodule

// File: rtl/fbf_read_mux.sv
module fbf_read_mux
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_mode_e         mode,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   array_rdata,
    output logic [DQ_W-1:0]   dq_out,
    output logic [1:0]        dq_oe
);
    logic              id_pick;
    logic [ADDR_W-1:0] id_rest;
    logic [DQ_W-1:0]   id_code;

    always_comb begin
        if (word_mode) begin
            id_pick = addr[1];
            id_rest = addr & ~ADDR_W'(2);
        end else begin
            id_pick = addr[0];
            id_rest = addr & ~ADDR_W'(1);
        end
        if (id_rest != '0)  id_code = '0;
        else if (id_pick)   id_code = DEV_CODE;
        else                id_code = MFR_CODE;
    end

    always_comb begin
        dq_out = '0;
        dq_oe  = 2'b00;
        case (mode)
            BM_READ: begin
                dq_out = narrow(word_mode, array_rdata);
                dq_oe  = {word_mode, 1'b1};
            end
            BM_ID: begin
                dq_out = narrow(word_mode, id_code);
                dq_oe  = {word_mode, 1'b1};
            end
            default: ;
        endcase
    end

    AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode == BM_PD || mode == BM_STBY || mode == BM_ODIS || mode == BM_WRITE)
            |-> dq_oe == 2'b00);  // R3
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> !dq_oe[1]);  // R4
    AST_ID_CODE: assert property (@(posedge clk) disable iff (rst)
        (mode == BM_ID && word_mode && addr == '0) |-> dq_out == MFR_CODE);  // R5
endmodule

// File: rtl/fbf_wr_capture.sv
module fbf_wr_capture
    import flash_fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_mode_e       mode,
    input  logic            pd_n,
    input  logic            word_mode,
    input  logic [DQ_W-1:0] dq_in,
    input  logic            vprog_ok,
    output logic            wr_accept,
    output logic            wr_reject,
    output logic [DQ_W-1:0] wr_data
);
    logic active;
    logic was_active;
    logic ending;

    assign active = (mode == BM_WRITE);
    assign ending = was_active && !active && pd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_active <= 1'b0;
            wr_accept  <= 1'b0;
            wr_reject  <= 1'b0;
            wr_data    <= '0;
        end else begin
            was_active <= active;
            wr_accept  <= ending && vprog_ok;
            wr_reject  <= ending && !vprog_ok;
            if (active)
                wr_data <= narrow(word_mode, dq_in);
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_accept || wr_reject) |=> !(wr_accept || wr_reject));  // R7
    AST_VPP_GATE: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> $past(vprog_ok));  // R8
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(wr_accept && wr_reject));  // R8
    AST_PD_NOPULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_accept || wr_reject) |-> $past(pd_n));  // R1
endmodule

// File: rtl/fbf_ready.sv
module fbf_ready (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    input  logic wsm_busy,
    input  logic erase_susp,
    output logic rb_pull_low
);
    assign rb_pull_low = pd_n && wsm_busy && !erase_susp;

    AST_RB_PD: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> !rb_pull_low);  // R1
    AST_RB_BUSY: assert property (@(posedge clk) disable iff (rst)
        (pd_n && wsm_busy && !erase_susp) |-> rb_pull_low);  // R10
    AST_RB_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!wsm_busy || erase_susp) |-> !rb_pull_low);  // R9
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    input  logic              word_mode,
    input  logic              id_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic [15:0]       array_rdata,
    input  logic              vprog_ok,
    input  logic              wsm_busy,
    input  logic              erase_susp,
    output logic [2:0]        bus_mode,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              wr_accept,
    output logic              wr_reject,
    output logic [15:0]       wr_data,
    output logic              rb_pull_low
);
    strobes_t  strobes;
    bus_mode_e mode;

    assign strobes = '{pd_n: pd_n, sel_a_n: sel_a_n, sel_b_n: sel_b_n,
                       rd_en_n: rd_en_n, wr_en_n: wr_en_n, id_sel: id_sel};
    assign bus_mode = mode;

    fbf_mode_dec u_dec (
        .clk(clk), .rst(rst), .strobes(strobes), .mode(mode)
    );

    fbf_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .mode(mode), .word_mode(word_mode),
        .addr(addr), .array_rdata(array_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    fbf_wr_capture u_wr (
        .clk(clk), .rst(rst), .mode(mode), .pd_n(pd_n),
        .word_mode(word_mode), .dq_in(dq_in), .vprog_ok(vprog_ok),
        .wr_accept(wr_accept), .wr_reject(wr_reject), .wr_data(wr_data)
    );

    fbf_ready u_rb (
        .clk(clk), .rst(rst), .pd_n(pd_n), .wsm_busy(wsm_busy),
        .erase_susp(erase_susp), .rb_pull_low(rb_pull_low)
    );
endmodule

// File: tb/sim_flash_bus_front.sv
`timescale 1ns/1ps
module sim_flash_bus_front;
    localparam int AW = 19;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
    logic word_mode = 1'b1, id_sel = 1'b0, vprog_ok = 1'b1, erase_susp = 1'b0;
    logic stub_busy = 1'b0, force_busy = 1'b0, use_stub = 1'b1;
    logic wsm_busy;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0, array_rdata = 16'h1234;
    logic [2:0]  bus_mode;
    logic [15:0] dq_out, wr_data;
    logic [1:0]  dq_oe;
    logic wr_accept, wr_reject, rb_pull_low;

    int total = 0;
    int bad = 0;
    int stub_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign wsm_busy = use_stub ? stub_busy : force_busy;

    flash_bus_front #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .pd_n(pd_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .word_mode(word_mode), .id_sel(id_sel),
        .addr(addr), .dq_in(dq_in), .array_rdata(array_rdata), .vprog_ok(vprog_ok),
        .wsm_busy(wsm_busy), .erase_susp(erase_susp), .bus_mode(bus_mode),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_accept(wr_accept), .wr_reject(wr_reject),
        .wr_data(wr_data), .rb_pull_low(rb_pull_low)
    );

    // busy stub: busy for four cycles after an accepted write
    always @(posedge clk) begin
        if (rst) begin stub_cnt <= 0; stub_busy <= 1'b0; end
        else if (wr_accept) begin stub_cnt <= 4; stub_busy <= 1'b1; end
        else if (stub_cnt > 1) stub_cnt <= stub_cnt - 1;
        else begin stub_cnt <= 0; stub_busy <= 1'b0; end
    end

    // reference model, registered part
    logic m_prev = 1'b0, m_acc = 1'b0, m_rej = 1'b0;
    logic [15:0] m_data = '0;

    function automatic int ref_mode();
        if (!pd_n) return 0;
        if (sel_a_n || sel_b_n) return 1;
        if (!wr_en_n) return 5;
        if (rd_en_n) return 2;
        if (id_sel) return 4;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev <= 1'b0; m_acc <= 1'b0; m_rej <= 1'b0; m_data <= '0;
        end else begin
            m_acc  <= m_prev && ref_mode() != 5 && pd_n && vprog_ok;
            m_rej  <= m_prev && ref_mode() != 5 && pd_n && !vprog_ok;
            m_prev <= (ref_mode() == 5);
            if (ref_mode() == 5) m_data <= word_mode ? dq_in : {8'h00, dq_in[7:0]};
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // combinational reference and comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int md;
            int exp_oe;
            int exp_dq;
            int code;
            int rest;
            string tag;
            md = ref_mode();
            exp_oe = 0;
            exp_dq = 0;
            case (md)
                0: tag = "R1";
                1: tag = "R2";
                2: tag = "R3";
                3: tag = "R4";
                4: tag = word_mode ? "R5" : "R6";
                default: tag = "R7";
            endcase
            if (md == 3) begin
                exp_oe = word_mode ? 3 : 1;
                exp_dq = word_mode ? int'(array_rdata) : int'(array_rdata[7:0]);
            end else if (md == 4) begin
                if (word_mode) begin
                    rest = int'(addr) & ~2;
                    code = addr[1] ? 16'h66A8 : 16'h00B0;
                end else begin
                    rest = int'(addr) & ~1;
                    code = addr[0] ? 16'h00A8 : 16'h00B0;
                end
                if (rest != 0) code = 0;
                exp_oe = word_mode ? 3 : 1;
                exp_dq = code;
            end
            check("R1", "bus_mode", int'(bus_mode), md);
            check(tag, "dq_oe", int'(dq_oe), exp_oe);
            if (exp_oe != 0) check(tag, "dq_out", int'(dq_out), exp_dq);
            check("R7", "wr_data", int'(wr_data), int'(m_data));
            check("R8", "wr_accept", int'(wr_accept), int'(m_acc));
            check("R8", "wr_reject", int'(wr_reject), int'(m_rej));
            check((wsm_busy && !rd_en_n) ? "R10" : "R9", "rb_pull_low", int'(rb_pull_low),
                  int'(pd_n && wsm_busy && !erase_susp));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus(input logic p, input logic a, input logic b,
                       input logic o, input logic w);
        pd_n = p; sel_a_n = a; sel_b_n = b; rd_en_n = o; wr_en_n = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);                         // reset state checked at negedges
        rst = 1'b0;
        step(2);
        // R1: power-down overrides everything
        bus(0, 0, 0, 0, 0); id_sel = 1; step(3);
        bus(0, 0, 0, 0, 1); step(2);
        // R2: standby via each select
        bus(1, 1, 0, 0, 1); step(2);
        bus(1, 0, 1, 0, 0); step(2);
        // R3: output disable
        bus(1, 0, 0, 1, 1); id_sel = 0; step(2);
        // R4: word and byte reads
        bus(1, 0, 0, 0, 1); array_rdata = 16'hBEEF; step(2);
        word_mode = 0; step(2); word_mode = 1;
        // R5: word identifiers
        id_sel = 1; addr = 0; step(1); addr = 2; step(1); addr = 3; step(1);
        addr = 19'h40002; step(1);
        // R6: byte identifiers
        word_mode = 0; addr = 0; step(1); addr = 1; step(1); addr = 3; step(1);
        word_mode = 1; id_sel = 0; addr = 0;
        // R7/R8: write ended by write strobe, accepted
        bus(1, 0, 0, 1, 0); dq_in = 16'hA5C3; step(3);
        bus(1, 0, 0, 1, 1); step(1);
        dq_in = 16'h0000; step(6);
        // R7: write ended by select, byte mode
        word_mode = 0; bus(1, 0, 0, 1, 0); dq_in = 16'hFF7E; step(2);
        bus(1, 1, 0, 1, 0); step(3); word_mode = 1;
        // R8: write refused without programming voltage
        vprog_ok = 0; bus(1, 0, 0, 1, 0); dq_in = 16'h1111; step(2);
        bus(1, 0, 0, 1, 1); step(3); vprog_ok = 1;
        // R1: write cut by power-down gives no pulse
        bus(1, 0, 0, 1, 0); dq_in = 16'h2222; step(2);
        bus(0, 0, 0, 1, 0); step(3);
        // R9/R10: busy with read strobe toggling, suspend, power-down
        use_stub = 0; force_busy = 1;
        bus(1, 0, 0, 0, 1); step(2);
        bus(1, 0, 0, 1, 1); step(2);
        erase_susp = 1; step(2); erase_susp = 0;
        bus(0, 0, 0, 0, 1); step(2);
        force_busy = 0; use_stub = 1;
        // random phase
        for (int i = 0; i < 600; i++) begin
            bus(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
                $urandom % 2, ($urandom % 3) == 0);
            word_mode  = $urandom % 2;
            id_sel     = $urandom % 2;
            vprog_ok   = ($urandom % 4) != 0;
            erase_susp = ($urandom % 5) == 0;
            addr       = (($urandom % 6) == 0) ? AW'($urandom) : AW'($urandom % 4);
            dq_in      = 16'($urandom);
            array_rdata = 16'($urandom);
            step(1 + $urandom % 2);
        end
        bus(1, 1, 1, 1, 1);
        step(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule